// File: doc/BRIEF.md
# SM4 Round-Key Generator with Indexed Subkey Memory

This block turns a 128-bit SM4 cipher key into the 32 round subkeys that the cipher's encrypt and decrypt engines consume. The key is split into four 32-bit words. Each word is mixed with a fixed system constant, and then a nonlinear recurrence runs over them, producing one new subkey per clock. Every subkey is written into a small internal memory at its round index. When the last one is stored, a completion flag rises.

The cipher engines share that memory through a synchronous read port: they present a round index and get the stored word one clock later. Encryption walks the indices upward and decryption walks them downward. Decryption starts from the very last subkey, so both engines must wait for the completion flag before they begin. A pulse on the key-load strobe clears the flag at any time, including in the middle of an expansion, and starts the schedule again from round 0.

Top module: `sm4_keyexp`

## Requirements
- R1: After synchronous active-low reset, `done` is 0 and every memory index reads back as 0.
- R2: The four starting words are the key words (key word 0 = `key_in[127:96]`, key word 3 = `key_in[31:0]`) XORed with A3B1BAC6, 56AA3350, 677D9197, B27022DC. For step i (0..31), the next word is computed as W[i+4] = W[i] ^ L(S(W[i+1]^W[i+2]^W[i+3]^C[i])). In this recurrence, S is the SM4 byte substitution applied to each of the four bytes, and L(b) = b ^ rotl(b,13) ^ rotl(b,23). C[i] has byte j (j=0 is the most significant byte) equal to ((4i+j)*7) mod 256. Memory index i holds W[i+4].
- R3: For key 0123456789ABCDEFFEDCBA9876543210, index 0 holds F12186F9 and index 31 holds 9124A012.
- R4: If the key-load strobe is sampled high at clock edge E0, `done` is low after edges E0 through E31 and high after edge E32. The block never writes the memory while `done` is high.
- R5: Once high, `done` stays high while `key_valid` stays low. A `key_valid` sampled high forces `done` low after that same edge.
- R6: A `key_valid` pulse during an expansion, including at the edge that would store the last subkey, abandons the old schedule. It restarts from index 0 with the new key, and the final memory contents are those of the new key alone.
- R7: `rd_data` presents the word stored at the `rd_addr` that was sampled on the previous clock edge. Back-to-back reads of different indices each return their own word.
- R8: While `key_valid` is low, changes on `key_in` alter neither `done` nor any stored subkey.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| key_valid | input | 1 | Key-load strobe; starts or restarts expansion |
| key_in | input | 128 | Cipher key, sampled when `key_valid` is high |
| rd_addr | input | 5 | Round index to read |
| done | output | 1 | All 32 subkeys are stored and valid |
| rd_data | output | 32 | Subkey at the previously sampled index |

## Verification
The embedded properties assume that `rst_n` is held low across at least one rising edge before the first key load. They make no assumption about when `key_valid` arrives: it may arrive during an expansion, at its final step, or while the block is idle. They also assume that a reader which needs valid data holds off until `done` is high. Words read during an expansion are only required to be stable, not meaningful. The stimulus follows these rules: it resets first and reads back the subkey memory only after `done` has risen. It places its restart pulses in the middle of a schedule and at the final step. It also drives random key values while the strobe is low, to show they are ignored.

// File: rtl/sm4_ks_pkg.sv
// Shared constants and pure functions for the SM4 key schedule.
// Assumes: 32-bit words made of four 8-bit lanes, 128-bit keys.
package sm4_ks_pkg;

    localparam int WORD_W = 32;
    localparam int BYTE_W = 8;
    localparam int LANES  = WORD_W / BYTE_W;
    localparam int KEY_W  = WORD_W * LANES;

    // System parameter mixed into the key words before the recurrence
    localparam logic [KEY_W-1:0] FK_ALL =
        128'hA3B1BAC6_56AA3350_677D9197_B27022DC;

    // Substitution box split into four 64-entry quarters, selected by x[7:6]
    localparam logic [511:0] SB_Q0 = {
        128'hd690e9fecce13db716b614c228fb2c05,
        128'h2b679a762abe04c3aa44132649860699,
        128'h9c4250f491ef987a33540b43edcfac62,
        128'he4b31ca9c908e89580df94fa758f3fa6};
    localparam logic [511:0] SB_Q1 = {
        128'h4707a7fcf37317ba83593c19e6854fa8,
        128'h686b81b27164da8bf8eb0f4b70569d35,
        128'h1e240e5e6358d1a225227c3b01217887,
        128'hd40046579fd327524c3602e7a0c4c89e};
    localparam logic [511:0] SB_Q2 = {
        128'heabf8ad240c738b5a3f7f2cef96115a1,
        128'he0ae5da49b341a55ad933230f58cb1e3,
        128'h1df6e22e8266ca60c02923ab0d534e6f,
        128'hd5db3745defd8e2f03ff6a726d6c5b51};
    localparam logic [511:0] SB_Q3 = {
        128'h8d1baf92bbddbc7f11d95c411f105ad8,
        128'h0ac13188a5cd7bbd2d74d012b8e5b4b0,
        128'h8969974a0c96777e65b9f109c56ec684,
        128'h18f07dec3adc4d2079ee5f3ed7cb3948};

    // Byte substitution: pick the quarter, shift the entry to the top
    function automatic logic [7:0] sbox(input logic [7:0] x);
        logic [511:0] q;
        case (x[7:6])
            2'd0:    q = SB_Q0;
            2'd1:    q = SB_Q1;
            2'd2:    q = SB_Q2;
            default: q = SB_Q3;
        endcase
        q = q << (8 * x[5:0]);
        return q[511:504];
    endfunction

    // Round constant for step i: byte j = ((4i+j)*7) mod 256, j=0 is MSB
    function automatic logic [WORD_W-1:0] ck_word(input int i);
        logic [WORD_W-1:0] w;
        w = '0;
        for (int j = 0; j < LANES; j++) begin
            w = {w[WORD_W-BYTE_W-1:0], 8'((4 * i + j) * 7)};
        end
        return w;
    endfunction

    // Left rotation of a 32-bit word
    function automatic logic [WORD_W-1:0] rotl32(input logic [WORD_W-1:0] v, input int n);
        return (v << n) | (v >> (WORD_W - n));
    endfunction

    // Linear diffusion used by the key schedule
    function automatic logic [WORD_W-1:0] lin_key(input logic [WORD_W-1:0] b);
        return b ^ rotl32(b, 13) ^ rotl32(b, 23);
    endfunction

endpackage

// File: rtl/ks_step.sv
// One key-schedule step, purely combinational.
// Computes w0 ^ L(S(w1 ^ w2 ^ w3 ^ rc)), with one substitution lane per byte.
// Assumes: rc is the round constant for the step being computed.
module ks_step
    import sm4_ks_pkg::*;
(
    input  logic [WORD_W-1:0] w0,
    input  logic [WORD_W-1:0] w1,
    input  logic [WORD_W-1:0] w2,
    input  logic [WORD_W-1:0] w3,
    input  logic [WORD_W-1:0] rc,
    output logic [WORD_W-1:0] w_next
);

    logic [WORD_W-1:0] mix;
    logic [WORD_W-1:0] subst;

    // Fold the three newer words with the round constant
    assign mix = w1 ^ w2 ^ w3 ^ rc;

    // Parallel byte substitution lanes
    generate
        for (genvar g = 0; g < LANES; g++) begin : g_lane
            assign subst[g*BYTE_W +: BYTE_W] = sbox(mix[g*BYTE_W +: BYTE_W]);
        end
    endgenerate

    // Diffuse and fold into the oldest word
    assign w_next = w0 ^ lin_key(subst);

endmodule

// File: rtl/ks_window.sv
// Sliding window of the four most recent schedule words.
// On load, it fills the window from the key XOR the system parameter.
// On each advance, it shifts in the newly computed word.
// Assumes: load has priority over adv; idx names the step being computed.
module ks_window
    import sm4_ks_pkg::*;
#(
    parameter int ROUNDS = 32,
    parameter int ADDR_W = $clog2(ROUNDS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              adv,
    input  logic [KEY_W-1:0]  key,
    input  logic [ADDR_W-1:0] idx,
    output logic [WORD_W-1:0] new_word
);

    logic [WORD_W-1:0] win [LANES];
    logic [WORD_W-1:0] rc;

    // Round constant for the current step
    assign rc = ck_word(int'(idx));

    ks_step u_step (
        .w0     (win[0]),
        .w1     (win[1]),
        .w2     (win[2]),
        .w3     (win[3]),
        .rc     (rc),
        .w_next (new_word)
    );

    // Window register: load from key, or shift the new word in
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int g = 0; g < LANES; g++) win[g] <= '0;
        end else if (load) begin
            for (int g = 0; g < LANES; g++)
                win[g] <= key[KEY_W-1-WORD_W*g -: WORD_W] ^ FK_ALL[KEY_W-1-WORD_W*g -: WORD_W];
        end else if (adv) begin
            for (int g = 0; g < LANES-1; g++) win[g] <= win[g+1];
            win[LANES-1] <= new_word;
        end
    end

endmodule

// File: rtl/ks_ctrl.sv
// Sequencer for the expansion.
// Tracks the step index, the busy phase and the completion flag.
// Assumes: key_valid may arrive at any cycle and always restarts from step 0.
module ks_ctrl #(
    parameter int ROUNDS = 32,
    parameter int ADDR_W = $clog2(ROUNDS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              key_valid,
    output logic              adv,
    output logic [ADDR_W-1:0] idx,
    output logic              done
);

    localparam logic [ADDR_W-1:0] LAST = ADDR_W'(ROUNDS - 1);

    logic busy;

    // A step is taken on every busy cycle that is not overridden by a reload
    assign adv = busy && !key_valid;

    // Step counter, busy phase and completion flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy <= 1'b0;
            idx  <= '0;
            done <= 1'b0;
        end else if (key_valid) begin
            busy <= 1'b1;
            idx  <= '0;
            done <= 1'b0;
        end else if (busy) begin
            if (idx == LAST) begin
                busy <= 1'b0;
                idx  <= '0;
                done <= 1'b1;
            end else begin
                idx <= idx + ADDR_W'(1);
            end
        end
    end

    AST_LOAD_RESTARTS: assert property (@(posedge clk) disable iff (!rst_n)
        key_valid |=> (!done && busy && idx == '0)); // R6

    AST_DONE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !key_valid) |=> done); // R5

    AST_DONE_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> ($past(busy) && $past(idx) == LAST && !$past(key_valid))); // R4

    AST_NO_STEP_WHEN_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        adv |-> !done); // R4

    AST_BUSY_DONE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy && done)); // R4

endmodule

// File: rtl/ks_store.sv
// Subkey memory with one write port and one synchronous read port.
// The read returns mem[rd_addr] one clock after the address is sampled.
// Assumes: the write and the read may target the same index in one cycle; the read then sees the old word.
module ks_store
    import sm4_ks_pkg::*;
#(
    parameter int ROUNDS = 32,
    parameter int ADDR_W = $clog2(ROUNDS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [WORD_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [WORD_W-1:0] rd_data
);

    logic [WORD_W-1:0] mem [ROUNDS];

    // Storage array: cleared on reset, written one subkey per step
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < ROUNDS; i++) mem[i] <= '0;
        end else if (wr_en) begin
            mem[wr_addr] <= wr_data;
        end
    end

    // Registered read port
    always_ff @(posedge clk) begin
        if (!rst_n) rd_data <= '0;
        else        rd_data <= mem[rd_addr];
    end

    AST_READ_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $stable(rd_addr) && !$past(wr_en)) |=> $stable(rd_data)); // R7

endmodule

// File: rtl/sm4_keyexp.sv
// Top level of the SM4 key expansion unit.
// Expands a loaded key into 32 subkeys at one per clock, stores them by index,
// flags completion, and serves indexed reads to the cipher engines.
// Assumes: readers wait for done before trusting rd_data.
module sm4_keyexp
    import sm4_ks_pkg::*;
#(
    parameter int ROUNDS = 32,
    parameter int ADDR_W = $clog2(ROUNDS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              key_valid,
    input  logic [KEY_W-1:0]  key_in,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic              done,
    output logic [WORD_W-1:0] rd_data
);

    logic              adv;
    logic [ADDR_W-1:0] idx;
    logic [WORD_W-1:0] new_word;

    ks_ctrl #(.ROUNDS(ROUNDS), .ADDR_W(ADDR_W)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .key_valid (key_valid),
        .adv       (adv),
        .idx       (idx),
        .done      (done)
    );

    ks_window #(.ROUNDS(ROUNDS), .ADDR_W(ADDR_W)) u_window (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (key_valid),
        .adv      (adv),
        .key      (key_in),
        .idx      (idx),
        .new_word (new_word)
    );

    ks_store #(.ROUNDS(ROUNDS), .ADDR_W(ADDR_W)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (adv),
        .wr_addr (idx),
        .wr_data (new_word),
        .rd_addr (rd_addr),
        .rd_data (rd_data)
    );

    AST_DONE_DROPS_ON_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        key_valid |=> !done); // R5

endmodule

// File: tb/test_sm4_keyexp.sv
`timescale 1ns/1ps
module test_sm4_keyexp;
    import sm4_ks_pkg::*;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         key_valid = 1'b0;
    logic [127:0] key_in = '0;
    logic [4:0]   rd_addr = '0;
    logic         done;
    logic [31:0]  rd_data;

    int nchk  = 0;
    int nfail = 0;

    logic [31:0] exp_rk [32];

    localparam logic [31:0] FK_TB [4] = '{32'hA3B1BAC6, 32'h56AA3350, 32'h677D9197, 32'hB27022DC};

    always #2.5 clk = ~clk;

    sm4_keyexp i_sm4_keyexp (
        .clk       (clk),
        .rst_n     (rst_n),
        .key_valid (key_valid),
        .key_in    (key_in),
        .rd_addr   (rd_addr),
        .done      (done),
        .rd_data   (rd_data)
    );

    function automatic logic [31:0] rl(input logic [31:0] v, input int n);
        return (v << n) | (v >> (32 - n));
    endfunction

    // Reference schedule built from R2
    task automatic build_ref(input logic [127:0] key);
        logic [31:0] k [36];
        logic [31:0] c, x, s;
        for (int i = 0; i < 4; i++) k[i] = key[127-32*i -: 32] ^ FK_TB[i];
        for (int i = 0; i < 32; i++) begin
            c = '0;
            for (int j = 0; j < 4; j++) c = {c[23:0], 8'((4 * i + j) * 7)};
            x = k[i+1] ^ k[i+2] ^ k[i+3] ^ c;
            s = {sbox(x[31:24]), sbox(x[23:16]), sbox(x[15:8]), sbox(x[7:0])};
            k[i+4] = k[i] ^ s ^ rl(s, 13) ^ rl(s, 23);
            exp_rk[i] = k[i+4];
        end
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] expv);
        nchk++;
        if (act !== expv) begin
            nfail++;
            $display("FAIL %s: actual %h expected %h at %0t", req, act, expv, $time);
        end
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    endtask

    // Single-cycle load strobe; returns at the negedge after the accepting edge
    task automatic pulse(input logic [127:0] key);
        @(negedge clk);
        key_in = key;
        key_valid = 1'b1;
        @(posedge clk);
        @(negedge clk);
        key_valid = 1'b0;
    endtask

    // Load a key and check the done timing of R4/R5
    task automatic run_key(input logic [127:0] key, input string req);
        int early;
        early = 0;
        build_ref(key);
        pulse(key);
        chk({req, "/R5 done low after load"}, 32'(done), 32'd0);
        for (int n = 1; n < 32; n++) begin
            @(posedge clk);
            @(negedge clk);
            if (done !== 1'b0) early++;
        end
        chk("R4 done stayed low during steps", 32'(early), 32'd0);
        @(posedge clk);
        @(negedge clk);
        chk("R4 done high after step 32", 32'(done), 32'd1);
    endtask

    // Back-to-back reads of all indices, one-cycle latency
    task automatic read_all(input string req);
        @(negedge clk);
        rd_addr = 5'd0;
        for (int a = 0; a < 32; a++) begin
            @(posedge clk);
            @(negedge clk);
            chk({req, "/R7 readback"}, rd_data, exp_rk[a]);
            rd_addr = 5'(a + 1);
        end
    endtask

    task automatic read_one(input logic [4:0] a, output logic [31:0] v);
        @(negedge clk);
        rd_addr = a;
        @(posedge clk);
        @(negedge clk);
        v = rd_data;
    endtask

    // Watchdog
    initial begin
        repeat (100000) @(posedge clk);
        nfail++;
        $display("FAIL R4 watchdog: actual run still active, expected completion");
        summary();
        $finish;
    end

    initial begin
        logic [31:0] v;
        logic [127:0] ka, kb;
        void'($urandom(32'd20240607));

        // R1: reset state
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        chk("R1 done after reset", 32'(done), 32'd0);
        read_one(5'd0, v);
        chk("R1 index 0 after reset", v, 32'd0);
        read_one(5'd31, v);
        chk("R1 index 31 after reset", v, 32'd0);

        // R3: known-answer vector
        run_key(128'h0123456789ABCDEFFEDCBA9876543210, "R3");
        read_one(5'd0, v);
        chk("R3 known rk0", v, 32'hF12186F9);
        read_one(5'd31, v);
        chk("R3 known rk31", v, 32'h9124A012);
        read_all("R2 known key");

        // R5: done holds while idle
        for (int n = 0; n < 5; n++) begin
            @(posedge clk);
            @(negedge clk);
            chk("R5 done held while idle", 32'(done), 32'd1);
        end

        // R2: random keys
        for (int t = 0; t < 5; t++) begin
            ka = {$urandom, $urandom, $urandom, $urandom};
            run_key(ka, "R2");
            read_all("R2 random key");
        end

        // R2: all-zero and all-one keys
        run_key('0, "R2");
        read_all("R2 zero key");
        run_key('1, "R2");
        read_all("R2 ones key");

        // R6: restart in mid-schedule
        ka = {$urandom, $urandom, $urandom, $urandom};
        kb = {$urandom, $urandom, $urandom, $urandom};
        pulse(ka);
        repeat (9) @(posedge clk);
        run_key(kb, "R6 mid restart");
        read_all("R6 mid restart");

        // R6: restart at the edge that would store the last subkey
        ka = {$urandom, $urandom, $urandom, $urandom};
        kb = {$urandom, $urandom, $urandom, $urandom};
        pulse(ka);
        repeat (31) @(posedge clk);
        run_key(kb, "R6 final-step restart");
        read_all("R6 final-step restart");

        // R8: key_in changes with key_valid low are ignored
        for (int n = 0; n < 8; n++) begin
            @(negedge clk);
            key_in = {$urandom, $urandom, $urandom, $urandom};
        end
        @(posedge clk);
        @(negedge clk);
        chk("R8 done unaffected by key_in", 32'(done), 32'd1);
        read_all("R8 contents unaffected");

        summary();
        $finish;
    end

endmodule